// File: doc/BRIEF.md
# Partitioned SIMD Adder

This block is a 64-bit two's-complement adder whose internal carry chain can be cut at byte-aligned lane boundaries. A two-bit width selector chooses how the word is partitioned: eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or one 64-bit lane. One pass through the adder performs every lane's addition (or subtraction) at the same time, and no carry crosses from one lane into the next.

A subtract input turns every lane into a two's-complement subtractor. Each lane's B field is inverted and a carry of one is injected at the lane's lowest bit. The carry leaving the top of each active lane is collected into a flag vector, one bit per lane. The lane count comes only from the width selector, and there is no per-lane enable: all lanes are computed and written on every accepted operation. Operands are taken when `valid_in` is high. The result and flags appear in registers one clock later, together with `valid_out`.

Top module: `psa_adder`

## Requirements
- R1: While `rst` is high at a clock edge, `valid_out`, `result` and `carry_flags` are all cleared to zero at that edge.
- R2: `valid_out` equals the value `valid_in` had at the previous rising clock edge.
- R3: `mode` selects the lane width: 0 gives 8-bit lanes, 1 gives 16-bit, 2 gives 32-bit and 3 gives a single 64-bit lane. Lane k occupies result bits [k*w+w-1 : k*w]. With `sub` low, each lane holds (A lane + B lane) mod 2^w, and no carry enters from the lane below.
- R4: With `sub` high, each lane holds (A lane - B lane) mod 2^w, computed independently in every lane.
- R5: `carry_flags[k]` is the carry out of the top bit of lane k (A + B for add, A + ~B + 1 for subtract, so 1 means no borrow). Flag bits with index at or above the lane count are 0.
- R6: When `valid_in` is low, `result` and `carry_flags` keep their previous values.
- R7: In 64-bit mode the carry propagates across all eight byte segments (for example, all-ones plus one gives zero with flag 1).
- R8: Every lane is always computed; there is no per-lane suppression of the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_in | input | 1 | Operands and controls are taken this cycle |
| mode | input | 2 | Lane width select: 0=8, 1=16, 2=32, 3=64 bits |
| sub | input | 1 | 1 = per-lane subtract, 0 = per-lane add |
| a | input | 64 | Packed operand A |
| b | input | 64 | Packed operand B |
| valid_out | output | 1 | Registered result is from an accepted operation last cycle |
| result | output | 64 | Registered packed per-lane sums or differences |
| carry_flags | output | 8 | Registered per-lane carry out, lane 0 in bit 0 |

## Verification
The properties assume that `mode`, `sub`, `a` and `b` carry defined values at every clock edge, including edges where `valid_in` is low. This matters because the checker samples them through `$past` whenever an antecedent could fire. The stimulus drives every input to a known value from time zero and changes them only at falling edges. During idle cycles it deliberately presents fresh operand values, so that the hold behaviour is exercised against real changes and not against constant inputs.

// File: rtl/psa_pkg.sv
package psa_pkg;
  typedef enum logic [1:0] {
    LW_8  = 2'd0,
    LW_16 = 2'd1,
    LW_32 = 2'd2,
    LW_64 = 2'd3
  } lane_width_e;
endpackage

// File: rtl/psa_lane_map.sv
module psa_lane_map #(
  parameter int NSEG = 8
) (
  input  logic [1:0]      mode,
  output logic [NSEG-1:0] seg_first,
  output logic [NSEG-1:0] seg_last
);
  localparam int IW = $clog2(NSEG) + 2;

  logic [IW-1:0] span_mask;

  always_comb begin
    span_mask = IW'((1 << mode) - 1);
  end

  for (genvar i = 0; i < NSEG; i++) begin : g_map
    localparam logic [IW-1:0] POS  = IW'(i);
    localparam logic [IW-1:0] NEXT = IW'(i + 1);
    always_comb begin
      seg_first[i] = (POS & span_mask) == '0;
      seg_last[i]  = (NEXT & span_mask) == '0;
    end
  end
endmodule

// File: rtl/psa_segment.sv
module psa_segment #(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0] op_a,
  input  logic [SEG_W-1:0] op_b,
  input  logic             invert_b,
  input  logic             c_in,
  output logic [SEG_W-1:0] sum,
  output logic             c_out
);
  logic [SEG_W-1:0] b_eff;
  logic [SEG_W:0]   wide;

  always_comb begin
    b_eff = invert_b ? ~op_b : op_b;
    wide  = {1'b0, op_a} + {1'b0, b_eff} + {{SEG_W{1'b0}}, c_in};
    sum   = wide[SEG_W-1:0];
    c_out = wide[SEG_W];
  end
endmodule

// File: rtl/psa_flag_pack.sv
module psa_flag_pack #(
  parameter int NSEG = 8
) (
  input  logic [1:0]      mode,
  input  logic [NSEG-1:0] seg_cout,
  output logic [NSEG-1:0] lane_flags
);
  localparam int SIW = (NSEG > 1) ? $clog2(NSEG) : 1;

  always_comb begin
    lane_flags = '0;
    for (int k = 0; k < NSEG; k++) begin
      int top_seg;
      logic [SIW-1:0] sel;
      top_seg = ((k + 1) << mode) - 1;
      sel = SIW'(top_seg);
      if (k < (NSEG >> mode)) lane_flags[k] = seg_cout[sel];
    end
  end
endmodule

// File: rtl/psa_out_reg.sv
module psa_out_reg #(
  parameter int DATA_W = 64,
  parameter int NSEG   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d_res,
  input  logic [NSEG-1:0]   d_flg,
  output logic              q_vld,
  output logic [DATA_W-1:0] q_res,
  output logic [NSEG-1:0]   q_flg
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_vld <= 1'b0;
      q_res <= '0;
      q_flg <= '0;
    end else begin
      q_vld <= load;
      if (load) begin
        q_res <= d_res;
        q_flg <= d_flg;
      end
    end
  end
endmodule

// File: rtl/psa_adder.sv
module psa_adder #(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      valid_in,
  input  logic [1:0]                mode,
  input  logic                      sub,
  input  logic [DATA_W-1:0]         a,
  input  logic [DATA_W-1:0]         b,
  output logic                      valid_out,
  output logic [DATA_W-1:0]         result,
  output logic [DATA_W/SEG_W-1:0]   carry_flags
);
  import psa_pkg::*;

  localparam int NSEG = DATA_W / SEG_W;

  lane_width_e      width_sel;
  logic [NSEG-1:0]  seg_first;
  logic [NSEG-1:0]  seg_last;
  logic [NSEG-1:0]  seg_cin;
  logic [NSEG-1:0]  seg_cout;
  logic [DATA_W-1:0] raw_sum;
  logic [NSEG-1:0]  lane_flags;

  assign width_sel = lane_width_e'(mode);

  psa_lane_map #(.NSEG(NSEG)) u_map (
    .mode      (width_sel),
    .seg_first (seg_first),
    .seg_last  (seg_last)
  );

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    if (s == 0) begin : g_base
      assign seg_cin[s] = sub;
    end else begin : g_link
      // a lane start cuts the chain and injects the subtract carry
      assign seg_cin[s] = seg_first[s] ? sub : seg_cout[s-1];
    end

    psa_segment #(.SEG_W(SEG_W)) u_seg (
      .op_a     (a[s*SEG_W +: SEG_W]),
      .op_b     (b[s*SEG_W +: SEG_W]),
      .invert_b (sub),
      .c_in     (seg_cin[s]),
      .sum      (raw_sum[s*SEG_W +: SEG_W]),
      .c_out    (seg_cout[s])
    );
  end

  psa_flag_pack #(.NSEG(NSEG)) u_flags (
    .mode       (width_sel),
    .seg_cout   (seg_cout),
    .lane_flags (lane_flags)
  );

  psa_out_reg #(.DATA_W(DATA_W), .NSEG(NSEG)) u_oreg (
    .clk   (clk),
    .rst   (rst),
    .load  (valid_in),
    .d_res (raw_sum),
    .d_flg (lane_flags),
    .q_vld (valid_out),
    .q_res (result),
    .q_flg (carry_flags)
  );

  logic unused_last;
  assign unused_last = ^seg_last;
endmodule

// File: rtl/psa_adder_chk.sv
module psa_adder_chk #(
  parameter int DATA_W = 64,
  parameter int SEG_W  = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    valid_in,
  input logic [1:0]              mode,
  input logic                    sub,
  input logic [DATA_W-1:0]       a,
  input logic [DATA_W-1:0]       b,
  input logic                    valid_out,
  input logic [DATA_W-1:0]       result,
  input logic [DATA_W/SEG_W-1:0] carry_flags
);
  localparam int NSEG = DATA_W / SEG_W;

  logic [SEG_W-1:0]  low_lane_sum;
  logic [DATA_W-1:0] full_diff;
  assign low_lane_sum = a[SEG_W-1:0] + b[SEG_W-1:0];
  assign full_diff    = a - b;

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!valid_out && result == '0 && carry_flags == '0));

  // R2
  vout_follow_chk: assert property (@(posedge clk) disable iff (rst)
    valid_in |=> valid_out);

  // R2
  vout_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> !valid_out);

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_in |=> ($stable(result) && $stable(carry_flags)));

  // R5
  flag_hi_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_in && mode == 2'd3) |=> carry_flags[NSEG-1:1] == '0);

  // R3
  lane0_add_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_in && !sub && mode == 2'd0) |=> result[SEG_W-1:0] == $past(low_lane_sum));

  // R4
  full_sub_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_in && sub && mode == 2'd3) |=> result == $past(full_diff));
endmodule

bind psa_adder psa_adder_chk #(.DATA_W(DATA_W), .SEG_W(SEG_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .valid_in    (valid_in),
  .mode        (mode),
  .sub         (sub),
  .a           (a),
  .b           (b),
  .valid_out   (valid_out),
  .result      (result),
  .carry_flags (carry_flags)
);

// File: tb/sim_psa_adder.sv
module sim_psa_adder;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [63:0] res;
    logic [7:0]  flg;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid_in = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        sub = 1'b0;
  logic [63:0] a = '0;
  logic [63:0] b = '0;
  logic        valid_out;
  logic [63:0] result;
  logic [7:0]  carry_flags;

  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  exp_t sb[$];
  logic [63:0] last_res = '0;
  logic [7:0]  last_flg = '0;
  logic [63:0] lfsr = 64'h1234_5678_9ABC_DEF1;

  always #(CLK_PERIOD/2) clk = ~clk;

  psa_adder u0 (
    .clk(clk), .rst(rst), .valid_in(valid_in), .mode(mode), .sub(sub),
    .a(a), .b(b), .valid_out(valid_out), .result(result),
    .carry_flags(carry_flags)
  );

  // reference: lane-by-lane arithmetic from the requirement text
  function automatic void model(input logic [63:0] x, input logic [63:0] y,
                                input logic [1:0] m, input logic s,
                                output logic [63:0] r, output logic [7:0] f);
    int w;
    int lanes;
    r = '0;
    f = '0;
    w = 8 << m;
    lanes = 64 / w;
    for (int k = 0; k < lanes; k++) begin
      logic [64:0] msk;
      logic [64:0] xv;
      logic [64:0] yv;
      logic [64:0] t;
      msk = (65'd1 << w) - 65'd1;
      xv = ({1'b0, x} >> (k * w)) & msk;
      yv = ({1'b0, y} >> (k * w)) & msk;
      if (s) yv = (~yv) & msk;
      t = xv + yv + {64'd0, s};
      r = r | 64'((t & msk) << (k * w));
      f[k] = t[w];
    end
  endfunction

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] x, input logic [63:0] y,
                       input logic [1:0] m, input logic s, input string tag);
    exp_t e;
    @(negedge clk);
    a = x; b = y; mode = m; sub = s; valid_in = 1'b1;
    model(x, y, m, s, e.res, e.flg);
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_in = 1'b0;
      a = ~a ^ 64'h0F0F_0F0F_0F0F_0F0F;
      b = b + 64'h0101_0101_0101_0101;
      mode = mode + 2'd1;
      sub = ~sub;
    end
  endtask

  // monitor: compare each produced result against the queue front
  always @(negedge clk) begin
    if (!rst && valid_out) begin
      if (sb.size() == 0) begin
        check("R2 unexpected valid_out", 72'd1, 72'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, {carry_flags, result}, {e.flg, e.res});
        last_res = e.res;
        last_flg = e.flg;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset", {carry_flags, result, 7'd0, valid_out}, 72'd0);
    @(negedge clk);
    rst = 1'b0;

    // R3 R5: 8-bit lanes with carries in alternating lanes
    drive(64'hFF00_FF00_FF00_FF01, 64'h0101_0101_0101_01FF, 2'd0, 1'b0, "R3 R5 add8");
    // R3: 16-bit lanes, carry from low byte into high byte within a lane
    drive(64'h00FF_FFFF_8000_1234, 64'h0001_0001_8000_0F0F, 2'd1, 1'b0, "R3 R5 add16");
    // R3: 32-bit lanes
    drive(64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001, 2'd2, 1'b0, "R3 R5 add32");
    // R7: full-width carry ripple
    drive(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd3, 1'b0, "R7 add64 ripple");
    // R4: subtract with borrow in some lanes
    drive(64'h0010_2030_4050_6070, 64'h0110_1040_3050_7060, 2'd0, 1'b1, "R4 R5 sub8");
    drive(64'h0000_8000_1234_FFFF, 64'h0001_8000_1235_0001, 2'd1, 1'b1, "R4 R5 sub16");
    drive(64'h0000_0000_FFFF_FFFF, 64'h0000_0001_FFFF_FFFF, 2'd2, 1'b1, "R4 R5 sub32");
    drive(64'h0000_0000_0000_0000, 64'h0000_0000_0000_0001, 2'd3, 1'b1, "R4 R5 sub64 borrow");
    // R8: zero operands still write every lane
    drive(64'h0, 64'h0, 2'd0, 1'b1, "R8 sub8 zero all lanes");
    drive(64'h0, 64'h0, 2'd0, 1'b0, "R8 add8 zero all lanes");
    idle(1);
    // R2: idle gives valid_out low
    @(negedge clk);
    check("R2 idle valid_out", {71'd0, valid_out}, 72'd0);
    // R6: outputs held during idle with changing inputs
    check("R6 hold", {carry_flags, result}, {last_flg, last_res});
    idle(3);
    @(negedge clk);
    check("R6 hold long", {carry_flags, result}, {last_flg, last_res});

    // R3 R4: pseudo-random mixture over all widths
    for (int i = 0; i < 48; i++) begin
      logic [63:0] x;
      logic [63:0] y;
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      x = lfsr * 64'h9E37_79B9_7F4A_7C15;
      y = {lfsr[31:0], lfsr[63:32]} ^ 64'hA5A5_5A5A_C3C3_3C3C;
      drive(x, y, 2'(i), i[2], i[2] ? "R4 random sub" : "R3 random add");
      if (i % 7 == 6) idle(1);
    end
    idle(2);
    @(negedge clk);
    check("R2 queue drained", 72'(sb.size()), 72'd0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule